// File: doc/BRIEF.md
# Interrupt Poll and Sequencing Unit

This unit is the interrupt front end of an 8-bit accumulator-style processor core. It samples the maskable interrupt, non-maskable interrupt and reset pins once per processor cycle, on the strobe that marks the falling edge of the second clock phase. At the instruction boundaries that the instruction sequencer flags, it decides whether a hardware interrupt sequence starts. It then counts that sequence through its cycles and picks the vector late, at the step that enters the vector fetch. Because the choice is made that late, a non-maskable request that arrives early enough takes over a software break or a maskable sequence that is already under way.

The sequencer tells the unit which flag value the poll must use. A return-from-interrupt restores the mask flag before the poll point. Clear-mask, set-mask and pull-status change the flag only after it, so the poll still sees the old value. A taken branch that does not cross a page suppresses the poll on its last cycle. During the reset sequence, the unit drives a write-inhibit over the three stack cycles, which turns the pushes into reads.

Top module: `irq_poll_seq`

## Requirements
- R1: All state changes only at a clock edge where `cyc_ce` is high; pins and strobes are looked at only there.
- R2: A high-to-low change of `nmi_pin_n` between two samples latches a pending NMI that stays set until a vector choice consumes it. A pin held low after that does not request again.
- R3: With `irq_pin_n` sampled low at an earlier step and an effective mask flag of 0, a step with `poll_pt` high starts a sequence: `seq_busy`=1, `seq_cycle`=1, `int_take`=1. With the flag at 1, the interrupt is masked.
- R4: With `poll_rti`=0, the poll uses `i_flag` as presented at that step (the value before a clear-mask, set-mask or pull-status update).
- R5: With `poll_rti`=1, the poll uses `i_restored` instead of `i_flag`.
- R6: `br_nopoll` high at a poll step suppresses the poll, so no sequence starts.
- R7: A sequence runs cycles 1 to 7 and goes idle on the step after cycle 7. `int_take` is high only in cycle 1 of a hardware or reset sequence, and never for a sequence started by `brk_go`. When idle, `vec_valid`, `int_take` and `wr_inhibit` are 0.
- R8: At the step from cycle 5 to cycle 6, the vector is chosen: reset gives 0xFFFC, a pending NMI gives 0xFFFA, and anything else gives 0xFFFE. `vec_addr` carries the base in cycle 6 and base+1 in cycle 7, with `vec_valid`=1. `vec_addr` is 0 otherwise.
- R9: An NMI latched by the sample that ends cycle 4 redirects a running break or maskable sequence to 0xFFFA. An NMI edge seen at the step that enters cycle 6 does not redirect it and stays pending.
- R10: While `res_pin_n` is sampled low, no sequence runs, and one that is running is cut off. One step after the pin is sampled high, a sequence starts at cycle 0, then runs 1 to 7 with vector 0xFFFC. `wr_inhibit` is high in cycles 3 to 5.
- R11: `rst_n` low clears all state: idle, nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| cyc_ce | input | 1 | One-clock strobe for the phase-2 falling edge (processor step) |
| irq_pin_n | input | 1 | Maskable interrupt pin, active low, level |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, active low, edge |
| res_pin_n | input | 1 | Processor reset pin, active low |
| i_flag | input | 1 | Current interrupt mask flag |
| i_restored | input | 1 | Mask flag value being restored by a return-from-interrupt |
| poll_pt | input | 1 | Instruction boundary poll point |
| poll_rti | input | 1 | Flag update lands before this poll |
| br_nopoll | input | 1 | Taken branch with no page crossing: no poll |
| brk_go | input | 1 | Software break sequence starts (cycle 1) |
| int_take | output | 1 | Force the interrupt sequence in place of the fetched opcode |
| seq_busy | output | 1 | A sequence is running |
| seq_cycle | output | 3 | Sequence cycle number |
| vec_valid | output | 1 | Vector fetch cycle |
| vec_addr | output | 16 | Vector byte address |
| wr_inhibit | output | 1 | Turn stack writes into reads |

## Verification
The bench builds the unit with default parameters: no extra pin synchronizer stages, early flag use for return-from-interrupt enabled, a seven-cycle sequence with the vector fetch at cycles 6 and 7, and the standard vector addresses. With zero sync stages, a pin change is visible at the very next step. This puts the hijack window boundary between cycle 4 and cycle 5 within reach of short directed scripts. Random phases then mix break strobes, reset pulses and NMI toggles, so that hijacks land at every cycle of a sequence.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

   typedef struct packed {
      logic irq_lvl;
      logic nmi_pend;
      logic res_low;
   } pin_state_t;

   typedef enum logic [1:0] {
      VK_IRQ = 2'd0,
      VK_NMI = 2'd1,
      VK_RST = 2'd2
   } vec_kind_e;

endpackage

// File: rtl/ips_pin_sample.sv
module ips_pin_sample
   import irq_poll_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       irq_n,
   input  logic       nmi_n,
   input  logic       res_n,
   input  logic       nmi_ack,
   output pin_state_t st
);
   logic [2:0] raw;
   logic       nmi_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign raw = {irq_n, nmi_n, res_n};
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b111;
            end else if (ce) begin
               stg[0] <= {irq_n, nmi_n, res_n};
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign raw = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= '0;
         nmi_prev <= 1'b1;
      end else if (ce) begin
         st.irq_lvl  <= ~raw[2];
         nmi_prev    <= raw[1];
         st.nmi_pend <= (nmi_prev & ~raw[1]) | (st.nmi_pend & ~nmi_ack);
         st.res_low  <= ~raw[0];
      end
   end

endmodule

// File: rtl/ips_poll.sv
module ips_poll
   import irq_poll_pkg::*;
#(
   parameter bit RTI_EARLY = 1'b1
) (
   input  pin_state_t pins,
   input  logic       poll_pt,
   input  logic       br_nopoll,
   input  logic       poll_rti,
   input  logic       i_flag,
   input  logic       i_restored,
   output logic       poll_req
);
   logic mask_eff;

   generate
      if (RTI_EARLY) begin : g_early
         assign mask_eff = poll_rti ? i_restored : i_flag;
      end else begin : g_late
         logic unused_rti;
         assign unused_rti = poll_rti ^ i_restored;
         assign mask_eff = i_flag;
      end
   endgenerate

   assign poll_req = poll_pt & ~br_nopoll &
                     (pins.nmi_pend | (pins.irq_lvl & ~mask_eff));

endmodule

// File: rtl/ips_seq.sv
module ips_seq
   import irq_poll_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SEQ_LAST   = 7,
   parameter int VEC_STEP   = 6,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE,
   parameter int CNT_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  pin_state_t        pins,
   input  logic              poll_req,
   input  logic              brk_go,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt,
   output logic              hw,
   output logic              is_rst,
   output logic [ADDR_W-1:0] vec_base,
   output logic              nmi_ack
);
   localparam logic [CNT_W-1:0] CHOICE = CNT_W'(VEC_STEP - 1);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(SEQ_LAST);

   logic      rst_pend;
   logic      at_choice;
   vec_kind_e kind;

   assign at_choice = busy && (cnt == CHOICE);
   assign nmi_ack   = ce && !pins.res_low && at_choice && !is_rst && pins.nmi_pend;

   always_comb begin
      if (is_rst)             kind = VK_RST;
      else if (pins.nmi_pend) kind = VK_NMI;
      else                    kind = VK_IRQ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         hw       <= 1'b0;
         is_rst   <= 1'b0;
         rst_pend <= 1'b0;
         vec_base <= '0;
      end else if (ce) begin
         if (pins.res_low) begin
            busy     <= 1'b0;
            rst_pend <= 1'b1;
         end else if (rst_pend) begin
            busy     <= 1'b1;
            cnt      <= '0;
            hw       <= 1'b1;
            is_rst   <= 1'b1;
            rst_pend <= 1'b0;
         end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
            if (at_choice) begin
               case (kind)
                  VK_RST:  vec_base <= VEC_RST;
                  VK_NMI:  vec_base <= VEC_NMI;
                  default: vec_base <= VEC_IRQ;
               endcase
            end
         end else if (brk_go) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(1);
            hw     <= 1'b0;
            is_rst <= 1'b0;
         end else if (poll_req) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(1);
            hw     <= 1'b1;
            is_rst <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_poll_seq.sv
module irq_poll_seq
   import irq_poll_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 0,
   parameter bit RTI_EARLY   = 1'b1,
   parameter int SEQ_LAST    = 7,
   parameter int VEC_STEP    = 6,
   parameter int PUSH_FIRST  = 3,
   parameter int PUSH_LAST   = 5,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE,
   localparam int CNT_W = $clog2(SEQ_LAST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_ce,
   input  logic              irq_pin_n,
   input  logic              nmi_pin_n,
   input  logic              res_pin_n,
   input  logic              i_flag,
   input  logic              i_restored,
   input  logic              poll_pt,
   input  logic              poll_rti,
   input  logic              br_nopoll,
   input  logic              brk_go,
   output logic              int_take,
   output logic              seq_busy,
   output logic [CNT_W-1:0]  seq_cycle,
   output logic              vec_valid,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              wr_inhibit
);
   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (VEC_STEP < 2 || VEC_STEP >= SEQ_LAST) begin : g_bad_vec
         $error("VEC_STEP must lie between 2 and SEQ_LAST-1");
      end
      if (PUSH_FIRST < 1 || PUSH_FIRST > PUSH_LAST || PUSH_LAST >= VEC_STEP) begin : g_bad_push
         $error("push window must end before the vector fetch");
      end
      if (VEC_NMI[0] || VEC_RST[0] || VEC_IRQ[0]) begin : g_bad_align
         $error("vector bases must be even");
      end
   endgenerate

   localparam logic [CNT_W-1:0] VSTEP = CNT_W'(VEC_STEP);
   localparam logic [CNT_W-1:0] PFIRST = CNT_W'(PUSH_FIRST);
   localparam logic [CNT_W-1:0] PLAST = CNT_W'(PUSH_LAST);

   pin_state_t        pins;
   logic              poll_req;
   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic              hw;
   logic              is_rst;
   logic [ADDR_W-1:0] vec_base;
   logic              nmi_ack;

   ips_pin_sample #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .ce(cyc_ce),
      .irq_n(irq_pin_n), .nmi_n(nmi_pin_n), .res_n(res_pin_n),
      .nmi_ack(nmi_ack), .st(pins)
   );

   ips_poll #(.RTI_EARLY(RTI_EARLY)) u_poll (
      .pins(pins), .poll_pt(poll_pt), .br_nopoll(br_nopoll),
      .poll_rti(poll_rti), .i_flag(i_flag), .i_restored(i_restored),
      .poll_req(poll_req)
   );

   ips_seq #(
      .ADDR_W(ADDR_W), .SEQ_LAST(SEQ_LAST), .VEC_STEP(VEC_STEP),
      .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .ce(cyc_ce), .pins(pins),
      .poll_req(poll_req), .brk_go(brk_go),
      .busy(busy), .cnt(cnt), .hw(hw), .is_rst(is_rst),
      .vec_base(vec_base), .nmi_ack(nmi_ack)
   );

   assign seq_busy   = busy;
   assign seq_cycle  = cnt;
   assign int_take   = busy && hw && (cnt == CNT_W'(1));
   assign vec_valid  = busy && (cnt >= VSTEP);
   assign vec_addr   = vec_valid ? (vec_base + ADDR_W'(cnt - VSTEP)) : '0;
   assign wr_inhibit = busy && is_rst && (cnt >= PFIRST) && (cnt <= PLAST);

endmodule

// File: rtl/irq_poll_seq_chk.sv
module irq_poll_seq_chk #(
   parameter int ADDR_W     = 16,
   parameter int SEQ_LAST   = 7,
   parameter int PUSH_FIRST = 3,
   parameter int PUSH_LAST  = 5,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE,
   localparam int CNT_W = $clog2(SEQ_LAST + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_ce,
   input logic              int_take,
   input logic              seq_busy,
   input logic [CNT_W-1:0]  seq_cycle,
   input logic              vec_valid,
   input logic [ADDR_W-1:0] vec_addr,
   input logic              wr_inhibit
);
   assert_state_on_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_ce |=> ($stable(seq_busy) && $stable(seq_cycle)));

   assert_vec_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr == VEC_NMI || vec_addr == VEC_NMI + 1'b1 ||
                     vec_addr == VEC_RST || vec_addr == VEC_RST + 1'b1 ||
                     vec_addr == VEC_IRQ || vec_addr == VEC_IRQ + 1'b1));

   assert_vec_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && seq_cycle == CNT_W'(SEQ_LAST)) |-> vec_addr[0]);

   assert_take_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int_take |-> (seq_busy && seq_cycle == CNT_W'(1)));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (!vec_valid && !int_take && !wr_inhibit));

   assert_inhibit_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |-> (seq_busy && !vec_valid && !int_take &&
                      seq_cycle >= CNT_W'(PUSH_FIRST) && seq_cycle <= CNT_W'(PUSH_LAST)));

endmodule

bind irq_poll_seq irq_poll_seq_chk #(
   .ADDR_W(ADDR_W), .SEQ_LAST(SEQ_LAST), .PUSH_FIRST(PUSH_FIRST),
   .PUSH_LAST(PUSH_LAST), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc_ce(cyc_ce), .int_take(int_take),
   .seq_busy(seq_busy), .seq_cycle(seq_cycle), .vec_valid(vec_valid),
   .vec_addr(vec_addr), .wr_inhibit(wr_inhibit)
);

// File: tb/irq_poll_seq_test.sv
module irq_poll_seq_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, cyc_ce, irq_n, nmi_n, res_n, i_flag, i_rest;
   logic poll_pt, poll_rti, br_nopoll, brk_go;
   logic int_take, seq_busy, vec_valid, wr_inhibit;
   logic [2:0]  seq_cycle;
   logic [15:0] vec_addr;

   irq_poll_seq uut (
      .clk(clk), .rst_n(rst_n), .cyc_ce(cyc_ce), .irq_pin_n(irq_n),
      .nmi_pin_n(nmi_n), .res_pin_n(res_n), .i_flag(i_flag),
      .i_restored(i_rest), .poll_pt(poll_pt), .poll_rti(poll_rti),
      .br_nopoll(br_nopoll), .brk_go(brk_go), .int_take(int_take),
      .seq_busy(seq_busy), .seq_cycle(seq_cycle), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .wr_inhibit(wr_inhibit)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   bit m_nprev, m_pend, m_irq, m_resl, m_rpend, m_busy, m_hw, m_isr;
   int m_cnt, m_vec;

   task automatic chk_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr();
      return (m_busy && m_cnt >= 6) ? m_vec + (m_cnt - 6) : 0;
   endfunction

   task automatic m_clear();
      m_nprev = 1; m_pend = 0; m_irq = 0; m_resl = 0; m_rpend = 0;
      m_busy = 0; m_hw = 0; m_isr = 0; m_cnt = 0; m_vec = 0;
   endtask

   task automatic m_step();
      bit edge_n, ack, msk;
      ack = 0;
      edge_n = m_nprev && !nmi_n;
      msk = poll_rti ? i_rest : i_flag;
      if (m_resl) begin
         m_busy = 0; m_rpend = 1;
      end else if (m_rpend) begin
         m_busy = 1; m_cnt = 0; m_hw = 1; m_isr = 1; m_rpend = 0;
      end else if (m_busy) begin
         if (m_cnt == 5) begin
            if (m_isr) m_vec = 16'hFFFC;
            else if (m_pend) begin m_vec = 16'hFFFA; ack = 1; end
            else m_vec = 16'hFFFE;
         end
         if (m_cnt == 7) m_busy = 0; else m_cnt++;
      end else if (brk_go) begin
         m_busy = 1; m_cnt = 1; m_hw = 0; m_isr = 0;
      end else if (poll_pt && !br_nopoll && (m_pend || (m_irq && !msk))) begin
         m_busy = 1; m_cnt = 1; m_hw = 1; m_isr = 0;
      end
      m_pend = edge_n ? 1'b1 : (ack ? 1'b0 : m_pend);
      m_nprev = nmi_n;
      m_irq = !irq_n;
      m_resl = !res_n;
   endtask

   task automatic cmp_model();
      chk_eq("R7", "busy", seq_busy, m_busy);
      if (m_busy) chk_eq("R7", "cycle", seq_cycle, m_cnt);
      chk_eq("R7", "take", int_take, m_busy && m_hw && m_cnt == 1);
      chk_eq("R8", "vec_valid", vec_valid, m_busy && m_cnt >= 6);
      chk_eq("R8", "vec_addr", vec_addr, exp_addr());
      chk_eq("R10", "wr_inhibit", wr_inhibit, m_busy && m_isr && m_cnt >= 3 && m_cnt <= 5);
   endtask

   // one processor step: a gap clock with scrambled inputs (R1), then the strobe
   task automatic step();
      logic [9:0] keep;
      keep = {irq_n, nmi_n, res_n, i_flag, i_rest, poll_pt, poll_rti, br_nopoll, brk_go, 1'b0};
      @(negedge clk);
      {irq_n, nmi_n, res_n, i_flag, i_rest, poll_pt, poll_rti, br_nopoll, brk_go} = 9'($urandom);
      @(negedge clk);
      {irq_n, nmi_n, res_n, i_flag, i_rest, poll_pt, poll_rti, br_nopoll, brk_go} = keep[9:1];
      cyc_ce = 1'b1;
      m_step();
      @(posedge clk);
      #1 cyc_ce = 1'b0;
      @(negedge clk);
      cmp_model();
   endtask

   task automatic steps(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic calm();
      poll_pt = 0; poll_rti = 0; br_nopoll = 0; brk_go = 0;
   endtask

   initial begin
      #500000;
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; cyc_ce = 0; irq_n = 1; nmi_n = 1; res_n = 1;
      i_flag = 1; i_rest = 1; calm();
      m_clear();
      repeat (4) @(negedge clk);
      // R11 reset state
      chk_eq("R11", "busy", seq_busy, 0);
      chk_eq("R11", "vec_valid", vec_valid, 0);
      chk_eq("R11", "take", int_take, 0);
      chk_eq("R11", "wr_inhibit", wr_inhibit, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1: pins low only in the gap clocks never request
      i_flag = 0; poll_pt = 1; step();
      chk_eq("R1", "no take", seq_busy, 0);
      calm();

      // R3: maskable request, full sequence
      irq_n = 0; step();
      chk_eq("R3", "no poll no start", seq_busy, 0);
      poll_pt = 1; step();
      chk_eq("R3", "take", int_take, 1);
      chk_eq("R3", "cycle", seq_cycle, 1);
      calm(); irq_n = 1;
      steps(4);
      chk_eq("R7", "cycle5", seq_cycle, 5);
      step();
      chk_eq("R8", "irq vec lo", vec_addr, 16'hFFFE);
      step();
      chk_eq("R8", "irq vec hi", vec_addr, 16'hFFFF);
      step();
      chk_eq("R7", "idle after 7", seq_busy, 0);

      // R4: old flag at poll
      i_flag = 1; irq_n = 0; step();
      poll_pt = 1; step();
      chk_eq("R4", "masked by old flag", seq_busy, 0);
      i_flag = 0; step();
      chk_eq("R4", "new flag next boundary", int_take, 1);
      calm(); irq_n = 1; steps(7);
      chk_eq("R7", "idle", seq_busy, 0);

      // R5: restored flag before poll
      irq_n = 0; step();
      i_flag = 1; i_rest = 0; poll_rti = 1; poll_pt = 1; step();
      chk_eq("R5", "restored 0 unmasks", int_take, 1);
      calm(); steps(7);
      i_flag = 0; i_rest = 1; poll_rti = 1; poll_pt = 1; step();
      chk_eq("R5", "restored 1 masks", seq_busy, 0);

      // R6: branch without page crossing
      poll_rti = 0; br_nopoll = 1; step();
      chk_eq("R6", "suppressed", seq_busy, 0);
      br_nopoll = 0; step();
      chk_eq("R6", "next poll taken", int_take, 1);
      calm(); irq_n = 1; steps(7);

      // R9: NMI takes over a break sequence
      i_flag = 1; brk_go = 1; step();
      chk_eq("R7", "brk cycle1", seq_cycle, 1);
      chk_eq("R7", "brk no take", int_take, 0);
      brk_go = 0; nmi_n = 0; step();
      steps(3);
      step();
      chk_eq("R9", "brk hijacked", vec_addr, 16'hFFFA);
      step();
      chk_eq("R9", "brk hijacked hi", vec_addr, 16'hFFFB);
      step();
      // R2: held low, no second request
      poll_pt = 1; step();
      chk_eq("R2", "held low no retrigger", seq_busy, 0);
      calm(); nmi_n = 1; step();

      // R9: edge too late for a running IRQ sequence
      i_flag = 0; irq_n = 0; step();
      poll_pt = 1; step();
      calm(); irq_n = 1; steps(4);
      nmi_n = 0; step();
      chk_eq("R9", "late edge keeps irq vec", vec_addr, 16'hFFFE);
      steps(2);
      i_flag = 1; poll_pt = 1; step();
      chk_eq("R2", "pending nmi taken", int_take, 1);
      calm(); steps(5);
      chk_eq("R2", "pending nmi vec", vec_addr, 16'hFFFA);
      steps(2);
      nmi_n = 1; step();

      // R10: reset cuts a sequence and runs its own
      i_flag = 0; irq_n = 0; step();
      poll_pt = 1; step();
      calm(); irq_n = 1; res_n = 0; step();
      chk_eq("R10", "still busy same step", seq_busy, 1);
      step();
      chk_eq("R10", "cut off", seq_busy, 0);
      step();
      res_n = 1; step();
      chk_eq("R10", "released idle", seq_busy, 0);
      step();
      chk_eq("R10", "cycle0", seq_cycle, 0);
      chk_eq("R10", "busy", seq_busy, 1);
      step();
      chk_eq("R10", "take", int_take, 1);
      step();
      chk_eq("R10", "c2 no inhibit", wr_inhibit, 0);
      for (int k = 3; k <= 5; k++) begin
         step();
         chk_eq("R10", "inhibit", wr_inhibit, 1);
      end
      step();
      chk_eq("R10", "rst vec", vec_addr, 16'hFFFC);
      chk_eq("R10", "c6 no inhibit", wr_inhibit, 0);
      step();
      chk_eq("R10", "rst vec hi", vec_addr, 16'hFFFD);
      step();

      // R11: chip reset mid sequence
      brk_go = 1; step(); brk_go = 0; step();
      rst_n = 0; @(negedge clk); m_clear();
      chk_eq("R11", "cleared", seq_busy, 0);
      rst_n = 1; @(negedge clk);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         irq_n     = ($urandom % 4) != 0;
         if ($urandom % 6 == 0) nmi_n = ~nmi_n;
         res_n     = ($urandom % 60) != 0;
         i_flag    = $urandom % 2;
         i_rest    = $urandom % 2;
         poll_pt   = ($urandom % 3) == 0;
         poll_rti  = ($urandom % 4) == 0;
         br_nopoll = ($urandom % 5) == 0;
         brk_go    = ($urandom % 15) == 0;
         step();
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule